// File: doc/BRIEF.md
# Dual-Lane Add-Compare-Select Unit

This unit is the compare-select stage of a trellis path-metric update on 40-bit accumulator words. On each strobe it takes two candidate words, `acx` and `acy`. It produces their difference (`acy` minus `acx`) and the surviving candidate, which is the larger one or, in minimum mode, the smaller one. It also records which candidate survived as a decision bit shifted into a 16-bit transition register.

In dual mode each word is split into two independent lanes. The upper lane covers bits 39..16: 16 data bits with 8 guard bits above them. The lower lane covers bits 15..0. Each lane has its own subtraction, overflow detection, optional saturation, comparison and transition register. In single mode the operands are treated as whole 40-bit signed numbers, and only the transition register chosen by `trn_pick` is shifted. Every result updates in the same clock edge. Nothing changes while the strobe is low.

Top module: `dual_cmp_select`

## Requirements
- R1: While `rst_n` is low, `diff_q`, `ext_q`, `ovf_q`, `carry_q`, `trn0_q` and `trn1_q` are cleared to zero. They stay zero until the first strobe.
- R2: When `op_valid` is 0 at a rising edge, all outputs and both transition registers keep their values, whatever the other inputs do.
- R3: In dual mode with saturation off, `diff_q[15:0]` is `acy[15:0]-acx[15:0]` modulo 2^16 and `diff_q[39:16]` is `acy[39:16]-acx[39:16]` modulo 2^24. In single mode, `diff_q` is `acy-acx` modulo 2^40.
- R4: Overflow is judged per lane in dual mode. The lower lane overflows when the exact signed difference of the two 16-bit fields falls outside -32768..32767. The upper lane overflows when the exact signed difference of the two 24-bit fields falls outside -32768..32767, which is the bit-31 position. `ovf_q` is the OR of both lanes. In single mode, `ovf_q` is set when the exact difference does not fit 40-bit signed.
- R5: With `sat_en`=1, an overflowing lane is replaced by its limit, chosen by the sign of the exact difference. The lower lane limits are 16'h7FFF and 16'h8000. The upper lane limits are 24'h007FFF and 24'hFF8000. In single mode the limits are 40'h7FFFFFFFFF and 40'h8000000000. A lane that does not overflow is unaffected.
- R6: `carry_q` is the carry out of bit 31 of the subtraction. In dual mode it is 1 when `acy[31:16]` is greater than or equal to `acx[31:16]` as unsigned numbers. In single mode it is 1 when `acy[31:0]` is greater than or equal to `acx[31:0]` as unsigned numbers.
- R7: In dual mode the upper lanes are compared using the signed 16-bit fields `[31:16]`, and the lower lanes using `[15:0]`. In maximum mode (`min_mode`=0), each lane of `ext_q` takes all of its bits from `acx` when that field is strictly greater, and from `acy` otherwise.
- R8: On every strobe in dual mode, `trn0_q` becomes {d_hi, trn0_q[15:1]} and `trn1_q` becomes {d_lo, trn1_q[15:1]}. The decision bit d is 0 when the `acx` lane is selected and 1 otherwise, so ties give 1.
- R9: In minimum mode (`min_mode`=1), `acx` is selected when it is strictly less. Otherwise `acy` is selected. The decision bit is 0 for `acx` and 1 for `acy`.
- R10: In single mode the full 40-bit signed values are compared and `ext_q` receives the winner. With `trn_pick`=0 only `trn0_q` shifts; with `trn_pick`=1 only `trn1_q` shifts. The other transition register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| dual_mode | input | 1 | 1: two lanes (24+16), 0: one 40-bit lane |
| min_mode | input | 1 | 1: keep the smaller candidate, 0: the larger |
| sat_en | input | 1 | Saturate overflowing differences |
| trn_pick | input | 1 | Transition register shifted in single mode |
| acx | input | 40 | First candidate word |
| acy | input | 40 | Second candidate word |
| diff_q | output | 40 | Difference acy minus acx |
| ext_q | output | 40 | Surviving candidate |
| ovf_q | output | 1 | Overflow of the last operation |
| carry_q | output | 1 | Carry out of bit 31 |
| trn0_q | output | 16 | Transition register of the upper lane |
| trn1_q | output | 16 | Transition register of the lower lane |

## Verification
The hardest case to reach is an upper-lane result whose low 16 bits look ordinary while the exact 24-bit difference has left the 16-bit range. The same applies to a case where the lane comparison, made on bits 31..16, disagrees with the guard bits that are carried along into `ext_q`. Fully random words make upper-lane overflow common but exact ties rare. The stimulus therefore mixes fully random words, words whose upper lane is a sign-extended 16-bit value, and directed cases: lane limits, equal fields, and guard bits that contradict the field sign. Every strobe is compared against a model that recomputes the results with 64-bit signed arithmetic. That model tracks its own copies of the transition registers.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // select codes for the transition register used in single mode
  typedef enum logic {TRN_UPPER = 1'b0, TRN_LOWER = 1'b1} trn_sel_e;

  // decision bit: 0 keeps the x candidate, 1 keeps the y candidate
  function automatic logic pick_bit(input logic x_gt, input logic x_lt,
                                    input logic want_min);
    return want_min ? ~x_lt : ~x_gt;
  endfunction
endpackage

// File: rtl/dcs_lane_diff.sv
module dcs_lane_diff #(
  parameter int W  = 16,
  parameter int SB = 15
) (
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] x_in,
  input  logic         sat_en,
  output logic [W-1:0] diff_out,
  output logic         ovf_out
);
  localparam logic [W-1:0] POS_LIM = {{(W-SB){1'b0}}, {SB{1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {{(W-SB){1'b1}}, {SB{1'b0}}};

  // exact difference one bit wider than the lane
  function automatic logic [W:0] exact_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    return {a[W-1], a} - {b[W-1], b};
  endfunction

  // the result fits when all bits from the sign position upward agree
  function automatic logic out_of_range(input logic [W:0] r);
    return ~((&r[W:SB]) | ~(|r[W:SB]));
  endfunction

  logic [W:0] exact_w;

  always_comb begin
    exact_w = exact_sub(y_in, x_in);
    ovf_out = out_of_range(exact_w);
    if (sat_en && ovf_out)
      diff_out = exact_w[W] ? NEG_LIM : POS_LIM;
    else
      diff_out = exact_w[W-1:0];
  end
endmodule

// File: rtl/dcs_lane_cmp.sv
module dcs_lane_cmp #(
  parameter int W  = 16,
  parameter int SB = 15
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         want_min,
  output logic [W-1:0] win_out,
  output logic         dec_out
);
  import dcs_pkg::*;

  logic x_gt_w;
  logic x_lt_w;

  always_comb begin
    x_gt_w  = $signed(x_in[SB:0]) > $signed(y_in[SB:0]);
    x_lt_w  = $signed(x_in[SB:0]) < $signed(y_in[SB:0]);
    dec_out = pick_bit(x_gt_w, x_lt_w, want_min);
    win_out = dec_out ? y_in : x_in;
  end
endmodule

// File: rtl/dcs_trn_reg.sv
module dcs_trn_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (shift_en)
      q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/dual_cmp_select.sv
module dual_cmp_select #(
  parameter int ACC_W  = 40,
  parameter int LO_W   = 16,
  parameter int DATA_W = 16,
  parameter int TRN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             dual_mode,
  input  logic             min_mode,
  input  logic             sat_en,
  input  logic             trn_pick,
  input  logic [ACC_W-1:0] acx,
  input  logic [ACC_W-1:0] acy,
  output logic [ACC_W-1:0] diff_q,
  output logic [ACC_W-1:0] ext_q,
  output logic             ovf_q,
  output logic             carry_q,
  output logic [TRN_W-1:0] trn0_q,
  output logic [TRN_W-1:0] trn1_q
);
  import dcs_pkg::*;

  localparam int HI_W = ACC_W - LO_W;
  localparam int CB   = LO_W + DATA_W - 1;

  // lane-level events, named for the checker
  logic [LO_W-1:0]  diff_lo_w, win_lo_w;
  logic [HI_W-1:0]  diff_hi_w, win_hi_w;
  logic [ACC_W-1:0] diff_full_w, win_full_w;
  logic             ovf_lo_w, ovf_hi_w, ovf_full_w;
  logic             dec_lo_w, dec_hi_w, dec_full_w;
  logic             carry_dual_w, carry_full_w;
  logic             shift0_w, shift1_w, din0_w, din1_w;
  logic [ACC_W-1:0] diff_nx, ext_nx;
  logic             ovf_nx, carry_nx;

  // subtractors: lower lane, upper lane, full width
  dcs_lane_diff #(.W(LO_W), .SB(LO_W-1)) u_sub_lo (
    .y_in(acy[LO_W-1:0]), .x_in(acx[LO_W-1:0]), .sat_en(sat_en),
    .diff_out(diff_lo_w), .ovf_out(ovf_lo_w));

  dcs_lane_diff #(.W(HI_W), .SB(DATA_W-1)) u_sub_hi (
    .y_in(acy[ACC_W-1:LO_W]), .x_in(acx[ACC_W-1:LO_W]), .sat_en(sat_en),
    .diff_out(diff_hi_w), .ovf_out(ovf_hi_w));

  dcs_lane_diff #(.W(ACC_W), .SB(ACC_W-1)) u_sub_full (
    .y_in(acy), .x_in(acx), .sat_en(sat_en),
    .diff_out(diff_full_w), .ovf_out(ovf_full_w));

  // comparators: sign at lane bit 15 (low), acc bit 31 (high), bit 39 (full)
  dcs_lane_cmp #(.W(LO_W), .SB(LO_W-1)) u_cmp_lo (
    .x_in(acx[LO_W-1:0]), .y_in(acy[LO_W-1:0]), .want_min(min_mode),
    .win_out(win_lo_w), .dec_out(dec_lo_w));

  dcs_lane_cmp #(.W(HI_W), .SB(DATA_W-1)) u_cmp_hi (
    .x_in(acx[ACC_W-1:LO_W]), .y_in(acy[ACC_W-1:LO_W]), .want_min(min_mode),
    .win_out(win_hi_w), .dec_out(dec_hi_w));

  dcs_lane_cmp #(.W(ACC_W), .SB(ACC_W-1)) u_cmp_full (
    .x_in(acx), .y_in(acy), .want_min(min_mode),
    .win_out(win_full_w), .dec_out(dec_full_w));

  // carry out of accumulator bit 31 for y + ~x + 1
  function automatic logic carry_hi(input logic [DATA_W-1:0] y, input logic [DATA_W-1:0] x);
    logic [DATA_W:0] s;
    s = {1'b0, y} + {1'b0, ~x} + {{DATA_W{1'b0}}, 1'b1};
    return s[DATA_W];
  endfunction

  function automatic logic carry_all(input logic [CB:0] y, input logic [CB:0] x);
    logic [CB+1:0] s;
    s = {1'b0, y} + {1'b0, ~x} + {{(CB+1){1'b0}}, 1'b1};
    return s[CB+1];
  endfunction

  always_comb begin
    carry_dual_w = carry_hi(acy[CB:LO_W], acx[CB:LO_W]);
    carry_full_w = carry_all(acy[CB:0], acx[CB:0]);
    if (dual_mode) begin
      diff_nx  = {diff_hi_w, diff_lo_w};
      ext_nx   = {win_hi_w, win_lo_w};
      ovf_nx   = ovf_hi_w | ovf_lo_w;
      carry_nx = carry_dual_w;
      din0_w   = dec_hi_w;
      din1_w   = dec_lo_w;
      shift0_w = op_valid;
      shift1_w = op_valid;
    end else begin
      diff_nx  = diff_full_w;
      ext_nx   = win_full_w;
      ovf_nx   = ovf_full_w;
      carry_nx = carry_full_w;
      din0_w   = dec_full_w;
      din1_w   = dec_full_w;
      shift0_w = op_valid && (trn_sel_e'(trn_pick) == TRN_UPPER);
      shift1_w = op_valid && (trn_sel_e'(trn_pick) == TRN_LOWER);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      diff_q  <= '0;
      ext_q   <= '0;
      ovf_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (op_valid) begin
      diff_q  <= diff_nx;
      ext_q   <= ext_nx;
      ovf_q   <= ovf_nx;
      carry_q <= carry_nx;
    end
  end

  dcs_trn_reg #(.W(TRN_W)) u_trn0 (
    .clk(clk), .rst_n(rst_n), .shift_en(shift0_w), .din(din0_w), .q(trn0_q));

  dcs_trn_reg #(.W(TRN_W)) u_trn1 (
    .clk(clk), .rst_n(rst_n), .shift_en(shift1_w), .din(din1_w), .q(trn1_q));
endmodule

// File: rtl/dual_cmp_select_chk.sv
module dual_cmp_select_chk #(
  parameter int ACC_W = 40,
  parameter int TRN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             dual_mode,
  input logic             sat_en,
  input logic             trn_pick,
  input logic [ACC_W-1:0] acx,
  input logic [ACC_W-1:0] acy,
  input logic [ACC_W-1:0] diff_q,
  input logic [ACC_W-1:0] ext_q,
  input logic             ovf_q,
  input logic [TRN_W-1:0] trn0_q,
  input logic [TRN_W-1:0] trn1_q,
  input logic             shift0_w,
  input logic             shift1_w,
  input logic             ovf_full_w
);
  localparam logic [ACC_W-1:0] TOP_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] BOT_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(diff_q) && $stable(ext_q) && $stable(ovf_q)
                   && $stable(trn0_q) && $stable(trn1_q)));

  p_trn0_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift0_w |=> trn0_q[TRN_W-2:0] == $past(trn0_q[TRN_W-1:1]));

  p_trn1_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift1_w |=> trn1_q[TRN_W-2:0] == $past(trn1_q[TRN_W-1:1]));

  p_single_keep1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dual_mode && !trn_pick) |=> $stable(trn1_q));

  p_single_keep0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dual_mode && trn_pick) |=> $stable(trn0_q));

  p_single_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dual_mode) |=> (ext_q == $past(acx) || ext_q == $past(acy)));

  p_single_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dual_mode && sat_en && ovf_full_w) |=>
      (ovf_q && (diff_q == TOP_LIM || diff_q == BOT_LIM)));
endmodule

bind dual_cmp_select dual_cmp_select_chk #(.ACC_W(ACC_W), .TRN_W(TRN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dual_mode(dual_mode),
  .sat_en(sat_en), .trn_pick(trn_pick), .acx(acx), .acy(acy),
  .diff_q(diff_q), .ext_q(ext_q), .ovf_q(ovf_q), .trn0_q(trn0_q),
  .trn1_q(trn1_q), .shift0_w(shift0_w), .shift1_w(shift1_w),
  .ovf_full_w(ovf_full_w));

// File: tb/dual_cmp_select_bench.sv
module dual_cmp_select_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, dual_mode, min_mode, sat_en, trn_pick;
  logic [39:0] acx, acy;
  logic [39:0] diff_q, ext_q;
  logic        ovf_q, carry_q;
  logic [15:0] trn0_q, trn1_q;

  int total = 0;
  int bad = 0;
  logic [15:0] m_trn0, m_trn1;

  always #4 clk = ~clk;

  dual_cmp_select u_dual_cmp_select (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dual_mode(dual_mode),
    .min_mode(min_mode), .sat_en(sat_en), .trn_pick(trn_pick),
    .acx(acx), .acy(acy), .diff_q(diff_q), .ext_q(ext_q), .ovf_q(ovf_q),
    .carry_q(carry_q), .trn0_q(trn0_q), .trn1_q(trn1_q));

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent restatement of the requirements with 64-bit arithmetic
  task automatic model(input logic dm, mn, st, pk, input logic [39:0] x, y,
                       output logic [39:0] d, e, output logic o, c);
    longint a, b, r;
    logic dec_h, dec_l, dec_f;
    if (dm) begin
      a = longint'($signed(x[15:0])); b = longint'($signed(y[15:0])); r = b - a;
      o = (r > 32767) || (r < -32768);
      d[15:0] = (st && o) ? ((r > 0) ? 16'h7FFF : 16'h8000) : 16'(r);
      a = longint'($signed(x[39:16])); b = longint'($signed(y[39:16])); r = b - a;
      d[39:16] = (st && ((r > 32767) || (r < -32768))) ?
                 ((r > 0) ? 24'h007FFF : 24'hFF8000) : 24'(r);
      o = o | (r > 32767) | (r < -32768);
      c = (y[31:16] >= x[31:16]);
      dec_h = mn ? !($signed(x[31:16]) < $signed(y[31:16]))
                 : !($signed(x[31:16]) > $signed(y[31:16]));
      dec_l = mn ? !($signed(x[15:0]) < $signed(y[15:0]))
                 : !($signed(x[15:0]) > $signed(y[15:0]));
      e = {dec_h ? y[39:16] : x[39:16], dec_l ? y[15:0] : x[15:0]};
      m_trn0 = {dec_h, m_trn0[15:1]};
      m_trn1 = {dec_l, m_trn1[15:1]};
    end else begin
      a = longint'($signed(x)); b = longint'($signed(y)); r = b - a;
      o = (r > 64'sh7F_FFFF_FFFF) || (r < -64'sh80_0000_0000);
      d = (st && o) ? ((r > 0) ? 40'h7F_FFFF_FFFF : 40'h80_0000_0000) : 40'(r);
      c = (y[31:0] >= x[31:0]);
      dec_f = mn ? !($signed(x) < $signed(y)) : !($signed(x) > $signed(y));
      e = dec_f ? y : x;
      if (pk) m_trn1 = {dec_f, m_trn1[15:1]};
      else    m_trn0 = {dec_f, m_trn0[15:1]};
    end
  endtask

  task automatic do_op(input logic dm, mn, st, pk, input logic [39:0] x, y);
    logic [39:0] d, e;
    logic o, c;
    @(negedge clk);
    op_valid = 1'b1; dual_mode = dm; min_mode = mn; sat_en = st;
    trn_pick = pk; acx = x; acy = y;
    model(dm, mn, st, pk, x, y, d, e, o, c);
    @(posedge clk); #1;
    check(st ? "R5 diff" : "R3 diff", diff_q, d);
    check("R4 ovf", {39'd0, ovf_q}, {39'd0, o});
    check("R6 carry", {39'd0, carry_q}, {39'd0, c});
    check(dm ? (mn ? "R9 ext" : "R7 ext") : "R10 ext", ext_q, e);
    check(dm ? "R8 trn0" : "R10 trn0", {24'd0, trn0_q}, {24'd0, m_trn0});
    check(dm ? "R8 trn1" : "R10 trn1", {24'd0, trn1_q}, {24'd0, m_trn1});
  endtask

  function automatic logic [39:0] rnd_word();
    logic [15:0] h;
    if ($urandom_range(1, 0) == 0)
      return {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
    h = 16'($urandom());
    return {{8{h[15]}}, h, 16'($urandom())};
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [39:0] keep_d, keep_e;
    logic [15:0] keep_t0, keep_t1;
    void'($urandom(32'd2024));
    rst_n = 1'b0; op_valid = 1'b0; dual_mode = 1'b0; min_mode = 1'b0;
    sat_en = 1'b0; trn_pick = 1'b0; acx = '0; acy = '0;
    m_trn0 = '0; m_trn1 = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 diff", diff_q, 40'd0);
    check("R1 ext", ext_q, 40'd0);
    check("R1 flags", {38'd0, ovf_q, carry_q}, 40'd0);
    check("R1 trn", {8'd0, trn0_q, trn1_q}, 40'd0);
    @(negedge clk); rst_n = 1'b1;

    // directed: lane limits and saturation in dual mode (R4, R5)
    do_op(1, 0, 1, 0, {24'hFF8000, 16'h8000}, {24'h007FFF, 16'h7FFF});
    do_op(1, 0, 1, 0, {24'h007FFF, 16'h7FFF}, {24'hFF8000, 16'h8000});
    do_op(1, 0, 0, 0, {24'hFF8000, 16'h8000}, {24'h007FFF, 16'h7FFF});
    // directed: ties select acy with decision 1 (R8, R9)
    do_op(1, 0, 0, 0, 40'h12_3456_789A, 40'h12_3456_789A);
    do_op(1, 1, 0, 0, 40'h00_8000_0001, 40'h00_8000_0001);
    // guard bits contradict field sign: compare uses bits 31:16 (R7)
    do_op(1, 0, 0, 0, 40'h7F_8000_0000, 40'h80_0001_0000);
    do_op(1, 1, 0, 0, 40'h7F_8000_0000, 40'h80_0001_0000);
    // single mode limits (R5, R10)
    do_op(0, 0, 1, 0, 40'h80_0000_0000, 40'h7F_FFFF_FFFF);
    do_op(0, 0, 1, 1, 40'h7F_FFFF_FFFF, 40'h80_0000_0000);
    do_op(0, 1, 0, 1, 40'hFF_FFFF_FFFF, 40'h00_0000_0001);
    do_op(0, 0, 0, 0, 40'h00_FFFF_0000, 40'h00_0001_0000);

    // R2: inputs change with the strobe low; state must hold
    keep_d = diff_q; keep_e = ext_q; keep_t0 = trn0_q; keep_t1 = trn1_q;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_valid = 1'b0; dual_mode = i[0]; min_mode = i[1]; sat_en = 1'b1;
      acx = rnd_word(); acy = rnd_word();
    end
    @(posedge clk); #1;
    check("R2 diff", diff_q, keep_d);
    check("R2 ext", ext_q, keep_e);
    check("R2 trn", {8'd0, trn0_q, trn1_q}, {8'd0, keep_t0, keep_t1});

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      do_op(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
            rnd_word(), rnd_word());
      if ($urandom_range(7, 0) == 0) begin
        @(negedge clk); op_valid = 1'b0; acx = rnd_word();
      end
    end
    @(negedge clk); op_valid = 1'b0;
    finish_run();
  end
endmodule